// File: doc/BRIEF.md
# Coulomb Counting Fuel Gauge Core

This block keeps the charge bookkeeping of a battery pack. On every measurement-period strobe it takes the integrated current for that period and removes every loss and uncertainty term from it. The terms are the current-measurement error, the gauge's own drain (rate times period length), self-discharge and the self-discharge error. It then adds the net change to a remaining-capacity register that is clamped between zero and the configured full capacity. The two error terms also accumulate into a separate maximum-error register. Every term is subtracted whatever the sign of the current, so the reported capacity errs low and never high.

Alongside the counter, the block tracks whether the pack is gaining charge or losing it. The gaining state needs the current to exceed a configured null band for a configured number of consecutive periods. The block also flags end of discharge when the cell voltage stays under a supplied limit for a configured number of consecutive periods. A host writes two alarm thresholds through a small command strobe: one for remaining capacity and one for remaining time, where the time value is an input. Low-capacity, low-time, end-of-discharge and discharging indications appear in a 16-bit status word. A clear request, raised by the power-mode logic on entry to low-voltage sleep, empties the capacity register.

Top module: `fg_core`

## Requirements
- R1: After reset, rem_cap and max_err are 0 and status equals 16'h0040: discharging state, no alarms, both thresholds 0.
- R2: On a cycle with period_tick high, rem_cap becomes rem_cap + meas_charge − cur_err − chip_drain×period_len − self_dis − self_dis_err. The new value is visible in the cycle after the strobe.
- R3: The updated capacity is clamped to 0 when the sum is negative and to full_cap when the sum exceeds it.
- R4: On each strobe, max_err grows by cur_err + self_dis_err, whatever the sign of meas_charge. It saturates at all ones and never decreases.
- R5: Status bit 6 is 1 in the discharging state and 0 in the charging state. The state switches only after the opposite condition has held on n_change consecutive strobes. The charging condition is cur_ma > null_curr, compared as signed values. A strobe that meets the current state's own condition restarts the count.
- R6: Status bit 11 (end-of-discharge) sets on the eod_recheck-th consecutive strobe with cell_mv < eod_mv. A strobe with cell_mv ≥ eod_mv restarts the count, and the bit stays set once set.
- R7: Status bit 11 clears on the strobe that switches the state to charging, and it is never 1 while bit 6 is 0.
- R8: A cmd_we cycle with cmd_code 8'h01 loads the capacity threshold from cmd_data, and cmd_code 8'h02 loads the time threshold. Any other code changes neither threshold.
- R9: On each strobe, status bit 9 is set to (capacity threshold ≠ 0 and updated rem_cap < capacity threshold). A zero threshold keeps the bit clear.
- R10: On each strobe, status bit 8 is set to (time threshold ≠ 0 and rem_time < time threshold). A zero threshold keeps the bit clear.
- R11: zero_req makes rem_cap 0 in the next cycle and takes priority over a strobe in the same cycle. max_err and the state still update on that strobe.
- R12: Without period_tick and zero_req, rem_cap, max_err and status hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_tick | input | 1 | One-cycle strobe per measurement period |
| meas_charge | input | CAP_W | Signed charge integrated over the period (positive = charging) |
| cur_err | input | TERM_W | Current-measurement error for the period |
| chip_drain | input | RATE_W | Gauge consumption per time unit |
| period_len | input | RATE_W | Period length in time units |
| self_dis | input | TERM_W | Self-discharge for the period |
| self_dis_err | input | TERM_W | Self-discharge error for the period |
| full_cap | input | CAP_W | Full-charge capacity, upper clamp |
| cur_ma | input | CUR_W | Signed corrected current |
| null_curr | input | CUR_W | Null-current band for the charging condition |
| n_change | input | CNT_W | Persistence count for a state change |
| cell_mv | input | VOLT_W | Cell voltage |
| eod_mv | input | VOLT_W | End-of-discharge voltage limit |
| eod_recheck | input | CNT_W | Persistence count for end of discharge |
| rem_time | input | 16 | Remaining run time |
| cmd_we | input | 1 | Threshold write strobe |
| cmd_code | input | 8 | Threshold select code |
| cmd_data | input | 16 | Threshold value |
| zero_req | input | 1 | Clear remaining capacity |
| rem_cap | output | CAP_W | Remaining capacity |
| max_err | output | CAP_W | Accumulated maximum error |
| status | output | 16 | Status word |

## Verification
Every result is registered once. Capacity, error and all four status bits change on the clock edge that samples period_tick, and a cleared capacity appears on the edge that samples zero_req. A threshold write affects only strobes that come after it. The bench drives each stimulus at a falling edge, holds it through one rising edge, drops it at the next falling edge and compares the outputs there, one edge after the stimulus. Persistence tests compare the status after the strobe just before the count is reached and after the strobe that reaches it.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int unsigned WORD_W = 16;

    typedef enum logic {
        ST_CD = 1'b0,
        ST_CI = 1'b1
    } chg_state_e;

    localparam int unsigned BIT_DSG      = 6;
    localparam int unsigned BIT_TIME_ALM = 8;
    localparam int unsigned BIT_CAP_ALM  = 9;
    localparam int unsigned BIT_TDA      = 11;

    localparam logic [7:0] CMD_CAP_THR  = 8'h01;
    localparam logic [7:0] CMD_TIME_THR = 8'h02;
endpackage

// File: rtl/fg_persist.sv
module fg_persist #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cond,
    input  logic [CNT_W-1:0] limit,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pst_t;

    pst_t           st_d, st_q;
    logic [CNT_W:0] inc;

    always_comb begin
        st_d = st_q;
        inc  = {1'b0, st_q.cnt} + 1'b1;
        hit  = tick && cond && (inc >= {1'b0, limit});
        if (tick) begin
            if (!cond || hit) st_d.cnt = '0;
            else              st_d.cnt = inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fg_accum.sv
module fg_accum #(
    parameter int CAP_W  = 24,
    parameter int TERM_W = 16,
    parameter int RATE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    zero_req,
    input  logic signed [CAP_W-1:0] meas,
    input  logic [TERM_W-1:0]       cur_err,
    input  logic [RATE_W-1:0]       drain,
    input  logic [RATE_W-1:0]       period,
    input  logic [TERM_W-1:0]       sd_amt,
    input  logic [TERM_W-1:0]       sd_err,
    input  logic [CAP_W-1:0]        full_cap,
    output logic [CAP_W-1:0]        cap_q_o,
    output logic [CAP_W-1:0]        err_q_o,
    output logic [CAP_W-1:0]        cap_next
);
    localparam int SUM_W  = CAP_W + 3;
    localparam int PROD_W = 2 * RATE_W;

    typedef struct packed {
        logic [CAP_W-1:0] cap;
        logic [CAP_W-1:0] err;
    } acc_t;

    acc_t                    st_d, st_q;
    logic [PROD_W-1:0]       drain_chg;
    logic signed [SUM_W-1:0] delta, sum;
    logic [CAP_W:0]          esum;

    function automatic logic signed [SUM_W-1:0] ext_t(input logic [TERM_W-1:0] v);
        return $signed({{(SUM_W-TERM_W){1'b0}}, v});
    endfunction

    function automatic logic signed [SUM_W-1:0] ext_p(input logic [PROD_W-1:0] v);
        return $signed({{(SUM_W-PROD_W){1'b0}}, v});
    endfunction

    always_comb begin
        st_d      = st_q;
        drain_chg = {{RATE_W{1'b0}}, drain} * {{RATE_W{1'b0}}, period};
        delta     = SUM_W'(meas) - ext_t(cur_err) - ext_p(drain_chg)
                  - ext_t(sd_amt) - ext_t(sd_err);
        sum       = $signed({3'b000, st_q.cap}) + delta;
        esum      = {1'b0, st_q.err} + (CAP_W+1)'(cur_err) + (CAP_W+1)'(sd_err);
        if (tick) begin
            if (sum < 0)
                st_d.cap = '0;
            else if (sum > $signed({3'b000, full_cap}))
                st_d.cap = full_cap;
            else
                st_d.cap = sum[CAP_W-1:0];
            st_d.err = esum[CAP_W] ? {CAP_W{1'b1}} : esum[CAP_W-1:0];
        end
        if (zero_req) st_d.cap = '0;
        cap_next = st_d.cap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_q_o = st_q.cap;
    assign err_q_o = st_q.err;
endmodule

// File: rtl/fg_core.sv
module fg_core #(
    parameter int CAP_W  = 24,
    parameter int TERM_W = 16,
    parameter int RATE_W = 8,
    parameter int CNT_W  = 4,
    parameter int VOLT_W = 16,
    parameter int CUR_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    period_tick,
    input  logic signed [CAP_W-1:0] meas_charge,
    input  logic [TERM_W-1:0]       cur_err,
    input  logic [RATE_W-1:0]       chip_drain,
    input  logic [RATE_W-1:0]       period_len,
    input  logic [TERM_W-1:0]       self_dis,
    input  logic [TERM_W-1:0]       self_dis_err,
    input  logic [CAP_W-1:0]        full_cap,
    input  logic signed [CUR_W-1:0] cur_ma,
    input  logic [CUR_W-1:0]        null_curr,
    input  logic [CNT_W-1:0]        n_change,
    input  logic [VOLT_W-1:0]       cell_mv,
    input  logic [VOLT_W-1:0]       eod_mv,
    input  logic [CNT_W-1:0]        eod_recheck,
    input  logic [15:0]             rem_time,
    input  logic                    cmd_we,
    input  logic [7:0]              cmd_code,
    input  logic [15:0]             cmd_data,
    input  logic                    zero_req,
    output logic [CAP_W-1:0]        rem_cap,
    output logic [CAP_W-1:0]        max_err,
    output logic [15:0]             status
);
    import fg_pkg::*;

    typedef struct packed {
        chg_state_e        chg;
        logic              tda;
        logic              cap_alm;
        logic              time_alm;
        logic [WORD_W-1:0] thr_cap;
        logic [WORD_W-1:0] thr_time;
    } core_t;

    core_t            st_d, st_q;
    logic             ci_cond, flip_cond, flip_hit, low_v, eod_hit;
    logic [CAP_W-1:0] cap_next;

    assign ci_cond   = $signed({cur_ma[CUR_W-1], cur_ma}) > $signed({1'b0, null_curr});
    assign flip_cond = ci_cond != (st_q.chg == ST_CI);
    assign low_v     = cell_mv < eod_mv;

    fg_persist #(.CNT_W(CNT_W)) u_flip (
        .clk(clk), .rst_n(rst_n), .tick(period_tick),
        .cond(flip_cond), .limit(n_change), .hit(flip_hit)
    );

    fg_persist #(.CNT_W(CNT_W)) u_eod (
        .clk(clk), .rst_n(rst_n), .tick(period_tick),
        .cond(low_v), .limit(eod_recheck), .hit(eod_hit)
    );

    fg_accum #(.CAP_W(CAP_W), .TERM_W(TERM_W), .RATE_W(RATE_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tick(period_tick), .zero_req(zero_req),
        .meas(meas_charge), .cur_err(cur_err), .drain(chip_drain),
        .period(period_len), .sd_amt(self_dis), .sd_err(self_dis_err),
        .full_cap(full_cap), .cap_q_o(rem_cap), .err_q_o(max_err),
        .cap_next(cap_next)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_we) begin
            case (cmd_code)
                CMD_CAP_THR:  st_d.thr_cap  = cmd_data;
                CMD_TIME_THR: st_d.thr_time = cmd_data;
                default: ;
            endcase
        end
        if (period_tick) begin
            if (flip_hit)
                st_d.chg = (st_q.chg == ST_CI) ? ST_CD : ST_CI;
            st_d.tda      = (st_d.chg == ST_CI) ? 1'b0 : (st_q.tda | eod_hit);
            st_d.cap_alm  = (st_q.thr_cap != '0) && (cap_next < CAP_W'(st_q.thr_cap));
            st_d.time_alm = (st_q.thr_time != '0) && (rem_time < st_q.thr_time);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.chg <= ST_CD;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status               = '0;
        status[BIT_DSG]      = (st_q.chg == ST_CD);
        status[BIT_TIME_ALM] = st_q.time_alm;
        status[BIT_CAP_ALM]  = st_q.cap_alm;
        status[BIT_TDA]      = st_q.tda;
    end
endmodule

// File: rtl/fg_core_chk.sv
module fg_core_chk #(
    parameter int CAP_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_tick,
    input logic             zero_req,
    input logic [CAP_W-1:0] full_cap,
    input logic [CAP_W-1:0] rem_cap,
    input logic [CAP_W-1:0] max_err,
    input logic [15:0]      status
);
    p_cap_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(period_tick) && !$past(zero_req)) |-> (rem_cap <= $past(full_cap)));

    p_zero_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (rem_cap == '0));

    p_err_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        max_err >= $past(max_err));

    p_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_tick && !zero_req) |=> ($stable(rem_cap) && $stable(max_err) && $stable(status)));

    p_eod_only_dsg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status[11] |-> status[6]);
endmodule

bind fg_core fg_core_chk #(.CAP_W(CAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .zero_req(zero_req),
    .full_cap(full_cap), .rem_cap(rem_cap), .max_err(max_err), .status(status)
);

// File: tb/tb_fg_core.sv
module tb_fg_core;
    localparam int CAP_W = 24;
    localparam int FULL  = 10000;
    localparam int ERR_MAX = (1 << CAP_W) - 1;
    localparam int NV = 7;

    // update vectors: meas, cur_err, drain, period, self-dis, self-dis err -> cap, err
    localparam int V_MEAS[NV] = '{5000, 4000, 2000, -3000, 0, -7000, 1234};
    localparam int V_CE  [NV] = '{10, 20, 0, 5, 100, 0, 0};
    localparam int V_DR  [NV] = '{2, 0, 0, 4, 10, 0, 0};
    localparam int V_PER [NV] = '{5, 5, 0, 10, 10, 0, 0};
    localparam int V_SD  [NV] = '{3, 0, 0, 5, 50, 0, 0};
    localparam int V_SDE [NV] = '{1, 0, 0, 2, 50, 0, 0};
    localparam int V_CAP [NV] = '{4976, 8956, 10000, 6948, 6648, 0, 1234};
    localparam int V_ERR [NV] = '{11, 31, 31, 38, 188, 188, 188};

    logic clk = 0, rst_n = 0;
    logic period_tick = 0;
    logic signed [CAP_W-1:0] meas_charge = '0;
    logic [15:0] cur_err = '0, self_dis = '0, self_dis_err = '0;
    logic [7:0]  chip_drain = '0, period_len = '0;
    logic [CAP_W-1:0] full_cap = CAP_W'(FULL);
    logic signed [15:0] cur_ma = '0;
    logic [15:0] null_curr = 16'd3;
    logic [3:0]  n_change = 4'd3, eod_recheck = 4'd3;
    logic [15:0] cell_mv = 16'd4000, eod_mv = 16'd3000, rem_time = 16'hFFFF;
    logic cmd_we = 0;
    logic [7:0]  cmd_code = '0;
    logic [15:0] cmd_data = '0;
    logic zero_req = 0;
    logic [CAP_W-1:0] rem_cap, max_err;
    logic [15:0] status;

    int n_chk = 0, n_bad = 0;
    int m_cap = 0, m_err = 0;

    always #2 clk = ~clk;

    fg_core dut (
        .clk(clk), .rst_n(rst_n), .period_tick(period_tick), .meas_charge(meas_charge),
        .cur_err(cur_err), .chip_drain(chip_drain), .period_len(period_len),
        .self_dis(self_dis), .self_dis_err(self_dis_err), .full_cap(full_cap),
        .cur_ma(cur_ma), .null_curr(null_curr), .n_change(n_change), .cell_mv(cell_mv),
        .eod_mv(eod_mv), .eod_recheck(eod_recheck), .rem_time(rem_time), .cmd_we(cmd_we),
        .cmd_code(cmd_code), .cmd_data(cmd_data), .zero_req(zero_req),
        .rem_cap(rem_cap), .max_err(max_err), .status(status)
    );

    function automatic logic [15:0] st(input bit dsg, input bit tda, input bit ca, input bit ta);
        logic [15:0] s = '0;
        s[6] = dsg; s[11] = tda; s[9] = ca; s[8] = ta;
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_tick(input int meas, input int ce, input int dr, input int per,
                           input int sd, input int sde, input bit z);
        int nc;
        @(negedge clk);
        meas_charge  = CAP_W'(meas);
        cur_err      = 16'(ce);  chip_drain = 8'(dr); period_len = 8'(per);
        self_dis     = 16'(sd);  self_dis_err = 16'(sde);
        zero_req     = z;
        period_tick  = 1;
        @(negedge clk);
        period_tick  = 0;
        zero_req     = 0;
        nc = m_cap + meas - ce - dr * per - sd - sde;
        if (nc < 0) nc = 0;
        if (nc > FULL) nc = FULL;
        m_cap = z ? 0 : nc;
        m_err = m_err + ce + sde;
        if (m_err > ERR_MAX) m_err = ERR_MAX;
    endtask

    task automatic quiet_tick();
        do_tick(0, 0, 0, 0, 0, 0, 1'b0);
    endtask

    task automatic wr_cmd(input logic [7:0] code, input logic [15:0] data);
        @(negedge clk);
        cmd_we = 1; cmd_code = code; cmd_data = data;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cap", int'(rem_cap), 0);
        check("R1 err", int'(max_err), 0);
        check("R1 status", int'(status), 16'h0040);

        // R2 R3 R4 vector table
        for (int i = 0; i < NV; i++) begin
            do_tick(V_MEAS[i], V_CE[i], V_DR[i], V_PER[i], V_SD[i], V_SDE[i], 1'b0);
            check("R2/R3 cap", int'(rem_cap), V_CAP[i]);
            check("R4 err", int'(max_err), V_ERR[i]);
            check("R5 status", int'(status), 16'h0040);
        end
        check("R2 model", int'(rem_cap), m_cap);

        // R12 no strobe: outputs hold
        @(negedge clk);
        meas_charge = -24'sd5000; cur_err = 16'd999; cur_ma = 16'sd500; cell_mv = 16'd100;
        rem_time = 16'd0;
        repeat (5) @(negedge clk);
        check("R12 cap hold", int'(rem_cap), 1234);
        check("R12 err hold", int'(max_err), 188);
        check("R12 status hold", int'(status), 16'h0040);
        cur_ma = 0; cell_mv = 16'd4000; rem_time = 16'hFFFF;

        // R5 charge-state persistence (n_change = 3)
        cur_ma = 16'sd3;
        repeat (3) quiet_tick();
        check("R5 at null stays dsg", int'(status), 16'h0040);
        cur_ma = 16'sd4;
        repeat (2) quiet_tick();
        check("R5 two of three", int'(status), 16'h0040);
        quiet_tick();
        check("R5 switch to chg", int'(status), 16'h0000);
        cur_ma = 16'sd0;
        repeat (2) quiet_tick();
        cur_ma = 16'sd10;
        quiet_tick();
        cur_ma = 16'sd0;
        repeat (2) quiet_tick();
        check("R5 count restarted", int'(status), 16'h0000);
        quiet_tick();
        check("R5 back to dsg", int'(status), 16'h0040);

        // R6 end of discharge (eod_recheck = 3)
        cell_mv = 16'd2900;
        repeat (2) quiet_tick();
        check("R6 two low", int'(status), 16'h0040);
        cell_mv = 16'd3000;
        quiet_tick();
        cell_mv = 16'd2900;
        repeat (2) quiet_tick();
        check("R6 restart at threshold", int'(status), 16'h0040);
        quiet_tick();
        check("R6 eod set", int'(status), int'(st(1, 1, 0, 0)));
        cell_mv = 16'd4000;
        quiet_tick();
        check("R6 eod sticky", int'(status), int'(st(1, 1, 0, 0)));

        // R7 eod clears on switch to charging
        n_change = 4'd2; cur_ma = 16'sd50;
        quiet_tick();
        check("R7 before switch", int'(status), int'(st(1, 1, 0, 0)));
        quiet_tick();
        check("R7 cleared", int'(status), 16'h0000);
        cur_ma = 16'sd0;
        repeat (2) quiet_tick();
        check("R7 dsg again", int'(status), 16'h0040);
        n_change = 4'd3;

        // R8 R9 capacity threshold
        wr_cmd(8'h01, 16'd500);
        wr_cmd(8'h03, 16'hFFFF);
        quiet_tick();
        check("R8 other code ignored", int'(status), 16'h0040);
        do_tick(-1000, 0, 0, 0, 0, 0, 1'b0);
        check("R2 cap", int'(rem_cap), 234);
        check("R9 cap alarm", int'(status), int'(st(1, 0, 1, 0)));
        wr_cmd(8'h01, 16'd0);
        quiet_tick();
        check("R9 zero threshold", int'(status), 16'h0040);

        // R10 time threshold
        wr_cmd(8'h02, 16'd100);
        rem_time = 16'd150;
        quiet_tick();
        check("R10 above", int'(status), 16'h0040);
        rem_time = 16'd99;
        quiet_tick();
        check("R10 time alarm", int'(status), int'(st(1, 0, 0, 1)));
        wr_cmd(8'h02, 16'd0);
        rem_time = 16'd0;
        quiet_tick();
        check("R10 zero threshold", int'(status), 16'h0040);
        rem_time = 16'hFFFF;

        // R11 zero request
        @(negedge clk); zero_req = 1;
        @(negedge clk); zero_req = 0;
        m_cap = 0;
        check("R11 cleared", int'(rem_cap), 0);
        check("R11 err kept", int'(max_err), 188);
        do_tick(700, 0, 0, 0, 0, 0, 1'b0);
        check("R2 regrow", int'(rem_cap), 700);
        do_tick(500, 7, 0, 0, 0, 0, 1'b1);
        check("R11 priority over strobe", int'(rem_cap), 0);
        check("R11 err still updates", int'(max_err), 195);

        // R4 saturation of the error register
        for (int k = 0; k < 130; k++) do_tick(0, 65535, 0, 0, 0, 65535, 1'b0);
        check("R4 err saturated", int'(max_err), ERR_MAX);
        check("R3 floor", int'(rem_cap), 0);

        summary();
        $finish;
    end
endmodule